// File: doc/BRIEF.md
# Multi-CPU Level-1 Interrupt Aggregator

This block gathers a set of level-sensitive interrupt sources, up to 128 of them, and folds them into a single interrupt line for each CPU. The sources are grouped into 32-bit words, and each source is one bit. The number of CPUs and the number of words are parameters. Every CPU owns a private register window on a simple 32-bit register bus. A window starts with one plain read/write enable word per source group, and the read-only status words follow it directly.

Each CPU line is asserted when at least one source is both pending and enabled in that CPU's enable bank. Software decides which CPU handles each source, and it does so by writing the enable banks. Source levels pass through a two-flop synchronizer before they reach the status words. The CPU outputs are registered.

Top module: `l1irq_aggregator`

## Requirements
- R1: Each register word holds 32 sources, one bit per source. Within a window the word order is reversed: the enable word at word slot k (byte offset 4*k, k < N) covers sources 32*(N-1-k) to 32*(N-1-k)+31. Source s is bit s mod 32 of its word.
- R2: The status word at slot N+k (byte offset 4*(N+k)) covers the same sources as enable slot k. It reads the synchronized raw source levels, unmasked, and it reads the same in every CPU window.
- R3: An enable word is a plain read/write register. A write replaces all 32 bits, and a read returns the last value written.
- R4: Each CPU has its own enable bank. A write into one CPU's window leaves every other CPU's enables unchanged.
- R5: Output irq_o[c] is 1 exactly when some source is both set in the status word and enabled in CPU c's bank. The output is registered, so it follows an enable write by one clock.
- R6: The window of CPU c begins at byte address c*8*N. The windows follow each other directly with no gap.
- R7: Writes to status offsets are ignored. They change no enable bit and no output.
- R8: After reset all enable bits are 0, every irq_o bit is 0, and bus_rdata is 0.
- R9: A read from an address beyond the last window returns 0. A write to such an address has no effect.
- R10: A change on a source input reaches irq_o on the third rising clock edge after it is applied: two synchronizer stages, then the output register.
- R11: Read data is registered and appears one clock after bus_rd. If a read and a write to the same enable word occur in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | 32*NUM_WORDS | Level interrupt sources, bit s is source s |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_CPUS | One interrupt line per CPU |

## Verification
A register read and a register write can land on the same enable word in the same cycle. The bench provokes this by raising both strobes together on one address with new data. The read must return the word's old contents, and a following read must return the new contents. A second collision is also checked: an enable write coinciding with a word that is already pending must move the CPU line exactly one clock later, never in the same cycle. The bench judges this by sampling irq_o on each side of that edge.

// File: rtl/l1irq_pkg.sv
package l1irq_pkg;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_ENABLE = 2'd1,
    ACC_STATUS = 2'd2
  } acc_kind_e;

  // Source word covered by a word slot inside one CPU window (reversed order)
  function automatic int slot_to_word(input int nw, input int slot);
    if (slot < nw) return nw - 1 - slot;
    return 2 * nw - 1 - slot;
  endfunction

  // Word slots that one CPU window occupies
  function automatic int slots_per_cpu(input int nw);
    return 2 * nw;
  endfunction

endpackage

// File: rtl/l1irq_sync.sv
module l1irq_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/l1irq_cpu_bank.sv
module l1irq_cpu_bank #(
  parameter int NUM_WORDS = 2,
  parameter int WIDX_W    = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [WIDX_W-1:0]              wr_word,
  input  logic [31:0]                    wdata,
  input  logic [NUM_WORDS-1:0][31:0]     status_i,
  output logic [NUM_WORDS-1:0][31:0]     en_o,
  output logic                           irq_o
);
  logic [NUM_WORDS-1:0][31:0] en_q;
  logic [NUM_WORDS-1:0]       word_live;
  logic                       irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q[wr_word] <= wdata;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_live[w] = |(status_i[w] & en_q[w]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |word_live;
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  assert_wr_replaces_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q[$past(wr_word)] == $past(wdata));

  assert_idle_bank_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));

  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|en_q));
endmodule

// File: rtl/l1irq_aggregator.sv
module l1irq_aggregator
  import l1irq_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [32*NUM_WORDS-1:0]   src_i,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [NUM_CPUS-1:0]       irq_o
);
  localparam int NSRC   = 32 * NUM_WORDS;
  localparam int SLOTS  = slots_per_cpu(NUM_WORDS);
  localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [NSRC-1:0]                           sync_q;
  logic [NUM_WORDS-1:0][31:0]                status_w;
  logic [NUM_CPUS-1:0][NUM_WORDS-1:0][31:0]  en_all;
  acc_kind_e                                 acc;
  logic [CPU_W-1:0]                          dec_cpu;
  logic [WIDX_W-1:0]                         dec_word;
  logic [31:0]                               rdata_q;
  int unsigned                               dec_wa;
  int unsigned                               dec_cpu_n;
  int unsigned                               dec_slot;

  l1irq_sync #(.WIDTH(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (sync_q)
  );

  assign status_w = sync_q;

  // Address decode: word address -> CPU window, slot, source word
  always_comb begin
    dec_wa    = 32'(bus_addr[ADDR_W-1:2]);
    dec_cpu_n = dec_wa / SLOTS;
    dec_slot  = dec_wa % SLOTS;
    acc       = ACC_NONE;
    dec_cpu   = '0;
    dec_word  = '0;
    if (dec_cpu_n < NUM_CPUS) begin
      acc      = (dec_slot < NUM_WORDS) ? ACC_ENABLE : ACC_STATUS;
      dec_cpu  = CPU_W'(dec_cpu_n);
      dec_word = WIDX_W'(slot_to_word(NUM_WORDS, int'(dec_slot)));
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic bank_wr;
    assign bank_wr = bus_wr && (acc == ACC_ENABLE) && (dec_cpu == CPU_W'(c));

    l1irq_cpu_bank #(.NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_wr),
      .wr_word  (dec_word),
      .wdata    (bus_wdata),
      .status_i (status_w),
      .en_o     (en_all[c]),
      .irq_o    (irq_o[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_rd) begin
      unique case (acc)
        ACC_ENABLE: rdata_q <= en_all[dec_cpu][dec_word];
        ACC_STATUS: rdata_q <= status_w[dec_word];
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

  assert_status_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && acc == ACC_STATUS) |=> $stable(en_all));

  assert_oob_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && acc == ACC_NONE) |=> $stable(en_all));

  assert_oob_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && acc == ACC_NONE) |=> bus_rdata == 32'd0);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_l1irq_aggregator.sv
module tb_l1irq_aggregator;
  localparam int NC = 2;
  localparam int NW = 2;
  localparam int WIN = 8 * NW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [32*NW-1:0]  src = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NC-1:0]     irq;

  int n_total = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  l1irq_aggregator #(.NUM_CPUS(NC), .NUM_WORDS(NW), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // {src, cpu0 enables, cpu1 enables, expected irq}
  localparam logic [193:0] VEC [7] = '{
    {64'h0, {64{1'b1}}, {64{1'b1}}, 2'b00},
    {64'h1, 64'h1, 64'h0, 2'b01},
    {64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000, 2'b10},
    {64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0000, 2'b10},
    {{64{1'b1}}, 64'h0, 64'h0, 2'b00},
    {64'h0000_0100_0000_0020, 64'h0000_0100_0000_0000, 64'h0000_0000_0000_0020, 2'b11},
    {64'h0000_0000_0002_0000, 64'h0000_0000_0002_0000, 64'h0000_0000_0002_0000, 2'b11}
  };

  // Bench-side address arithmetic: last word first in each group
  function automatic logic [7:0] en_addr(int cpu, int word);
    return 8'(cpu * WIN + 4 * (NW - 1 - word));
  endfunction
  function automatic logic [7:0] st_addr(int cpu, int word);
    return 8'(cpu * WIN + 4 * NW + 4 * (NW - 1 - word));
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] e0, e1;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(irq == 2'b00, "R8 irq after reset", 64'(irq), 64'h0);
    check(rdata == 32'h0, "R8 rdata after reset", 64'(rdata), 64'h0);
    rst_n = 1'b1;
    bus_read(en_addr(0, 0), r);
    check(r == 32'h0, "R8 cpu0 enable word0", 64'(r), 64'h0);
    bus_read(en_addr(1, 1), r);
    check(r == 32'h0, "R8 cpu1 enable word1", 64'(r), 64'h0);

    // Vector table: R1 R2 R4 R5 R6
    for (int i = 0; i < 7; i++) begin
      e0 = VEC[i][129:66];
      e1 = VEC[i][65:2];
      for (int w = 0; w < NW; w++) begin
        bus_write(en_addr(0, w), e0[32*w +: 32]);
        bus_write(en_addr(1, w), e1[32*w +: 32]);
      end
      @(negedge clk);
      src = VEC[i][193:130];
      repeat (4) @(negedge clk);
      check(irq == VEC[i][1:0], $sformatf("R5 R1 vector %0d irq", i), 64'(irq),
            64'(VEC[i][1:0]));
      bus_read(st_addr(1, 1), r);
      check(r == src[63:32], $sformatf("R2 vector %0d cpu1 status hi", i), 64'(r),
            64'(src[63:32]));
      bus_read(st_addr(0, 0), r);
      check(r == src[31:0], $sformatf("R2 vector %0d cpu0 status lo", i), 64'(r),
            64'(src[31:0]));
      bus_read(en_addr(0, 1), r);
      check(r == e0[63:32], $sformatf("R4 R6 vector %0d cpu0 enable hi", i), 64'(r),
            64'(e0[63:32]));
      bus_read(en_addr(1, 0), r);
      check(r == e1[31:0], $sformatf("R4 R6 vector %0d cpu1 enable lo", i), 64'(r),
            64'(e1[31:0]));
    end

    // R3 whole-word replace, no OR-in
    bus_write(en_addr(0, 0), 32'hA5A5_A5A5);
    bus_write(en_addr(0, 0), 32'h0000_FFFF);
    bus_read(en_addr(0, 0), r);
    check(r == 32'h0000_FFFF, "R3 replace word", 64'(r), 64'h0000_FFFF);

    // R10 latency: cpu0 enables only source 3
    bus_write(en_addr(0, 0), 32'h8);
    bus_write(en_addr(0, 1), 32'h0);
    bus_write(en_addr(1, 0), 32'h0);
    bus_write(en_addr(1, 1), 32'h0);
    @(negedge clk);
    src = '0;
    repeat (4) @(negedge clk);
    src = 64'h8;
    @(negedge clk);
    @(negedge clk);
    check(irq[0] == 1'b0, "R10 irq still low after two edges", 64'(irq), 64'h0);
    @(negedge clk);
    check(irq[0] == 1'b1, "R10 irq high on third edge", 64'(irq), 64'h1);

    // R5 enable write with source already pending: one-clock response
    @(negedge clk);
    wr = 1'b1; addr = en_addr(1, 0); wdata = 32'h8;
    #1;
    check(irq[1] == 1'b0, "R5 cpu1 low in write cycle", 64'(irq), 64'h0);
    @(negedge clk);
    wr = 1'b0;
    check(irq[1] == 1'b0, "R5 cpu1 low right after write edge", 64'(irq), 64'h0);
    @(negedge clk);
    check(irq[1] == 1'b1, "R5 cpu1 high one clock after write", 64'(irq), 64'h1);

    // R7 status write ignored
    bus_write(st_addr(0, 0), 32'hFFFF_FFFF);
    bus_write(st_addr(1, 1), 32'hFFFF_FFFF);
    bus_read(en_addr(0, 1), r);
    check(r == 32'h0, "R7 enable untouched by status write", 64'(r), 64'h0);
    bus_read(en_addr(0, 0), r);
    check(r == 32'h8, "R7 enable lo kept", 64'(r), 64'h8);
    bus_read(st_addr(0, 0), r);
    check(r == 32'h8, "R7 status still raw", 64'(r), 64'h8);
    check(irq == 2'b11, "R7 outputs unchanged", 64'(irq), 64'h3);

    // R9 out-of-range
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_write(8'hFC, 32'hFFFF_FFFF);
    bus_read(8'h20, r);
    check(r == 32'h0, "R9 read 0x20", 64'(r), 64'h0);
    bus_read(8'hFC, r);
    check(r == 32'h0, "R9 read 0xFC", 64'(r), 64'h0);
    bus_read(en_addr(1, 1), r);
    check(r == 32'h0, "R9 enable untouched", 64'(r), 64'h0);

    // R11 read and write same word in one cycle
    @(negedge clk);
    rd = 1'b1; wr = 1'b1; addr = en_addr(1, 1); wdata = 32'h1234_5678;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    check(rdata == 32'h0, "R11 collision returns old", 64'(rdata), 64'h0);
    bus_read(en_addr(1, 1), r);
    check(r == 32'h1234_5678, "R11 new value after", 64'(r), 64'h1234_5678);

    finished = 1;
    summary();
  end
endmodule